// File: doc/BRIEF.md
# Banked Data Address Generator

This block turns the short file-register field carried in an instruction into a full 12-bit data-memory address. It keeps a 4-bit bank register of its own, which can be loaded only by a dedicated load-bank command word. With the banked selector set, the bank register supplies the high bits of the address. With the selector clear, the bank register plays no part. Instead, the 8-bit field reaches a fixed 256-byte window: its low half maps to the bottom of memory and its high half maps to the top of the last bank, where the special function registers live.

The address and a flag marking the special-function region are purely combinational, so a datapath can use them in the same cycle the instruction is decoded. A load-bank command changes the bank register on the following clock edge. Any address formed in the command's own cycle still uses the old bank.

Top module: `banked_addr_gen`

## Requirements
- R1: While reset is held, and right after it is released, the bank register (`bank_value`) reads 0x0.
- R2: When `instr_valid` is 1 and `instr_word` has bits [15:4] equal to 0x010 (word form 0000 0001 0000 kkkk), `bank_value` equals kkkk after the next rising clock edge.
- R3: In the cycle a load-bank command is presented, `data_addr` and `sfr_region` are still formed from the old bank value.
- R4: A word whose bits [15:4] differ from 0x010, or any word presented with `instr_valid` at 0, leaves `bank_value` unchanged.
- R5: With `access_sel` = 1 (banked), `data_addr` equals `bank_value` in bits [11:8] and `file_field` in bits [7:0]. For example, field 0x70 with bank 0x2 gives 0x270.
- R6: With `access_sel` = 0 and `file_field` bit 7 at 0, `data_addr` = 0x000 + `file_field` (0x000 to 0x07F), whatever the bank value.
- R7: With `access_sel` = 0 and `file_field` bit 7 at 1, `data_addr` = 0xF00 + `file_field` (0xF80 to 0xFFF), whatever the bank value.
- R8: `sfr_region` is 1 exactly when `data_addr` is 0xF80 or higher.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | `instr_word` holds a command this cycle |
| instr_word | input | 16 | Command word; the load-bank form updates the bank register |
| file_field | input | 8 | File-register field taken from the instruction |
| access_sel | input | 1 | 1 = banked (use the bank register), 0 = fixed access window |
| bank_value | output | 4 | Current bank register contents |
| data_addr | output | 12 | Resolved data-memory address |
| sfr_region | output | 1 | Address lies in 0xF80 to 0xFFF |

## Verification
The bench targets the seam at field 0x7F/0x80 in access mode. A design that picked the window half from the wrong bit would send 0x80 to 0x080, or 0x7F to 0xF7F. It sets bank 0xF in banked mode and probes fields 0x7F and 0x80, so a region flag keyed on the access mode rather than on the final address would misreport 0xF80 or 0xF7F. It sends words that differ from the load-bank form by a single bit, and a decoder that checks too few opcode bits would change the bank on them. It also reads the address in the same cycle as a load, so a bank register bypassed combinationally would show the new bank one cycle early.

// File: rtl/banked_addr_pkg.sv
package banked_addr_pkg;

    localparam int BANK_W  = 4;
    localparam int FIELD_W = 8;
    localparam int CMD_W   = 16;
    localparam int ADDR_W  = BANK_W + FIELD_W;

    // Upper bits of a load-bank command; low BANK_W bits carry the literal.
    localparam int OPC_W = CMD_W - BANK_W;
    localparam logic [OPC_W-1:0] LOAD_BANK_OPC = OPC_W'(12'h010);

    // First address of the special-function region (top half of last bank).
    localparam logic [ADDR_W-1:0] SFR_BASE =
        ADDR_W'((1 << ADDR_W) - (1 << (FIELD_W - 1)));

    localparam logic [BANK_W-1:0] BANK_RESET = '0;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } bank_state_t;

endpackage

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode
    import banked_addr_pkg::*;
(
    input  logic              instr_valid,
    input  logic [CMD_W-1:0]  instr_word,
    output logic              load_en,
    output logic [BANK_W-1:0] load_lit
);

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc      = instr_word[CMD_W-1:BANK_W];
        load_lit = instr_word[BANK_W-1:0];
        load_en  = instr_valid && (opc == LOAD_BANK_OPC);
    end

endmodule

// File: rtl/bank_reg.sv
module bank_reg
    import banked_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [BANK_W-1:0] load_lit,
    output logic [BANK_W-1:0] bank_q
);

    bank_state_t state_d;
    bank_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (load_en) begin
            state_d.bank = load_lit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.bank <= BANK_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank_q = state_q.bank;

endmodule

// File: rtl/addr_form.sv
module addr_form
    import banked_addr_pkg::*;
(
    input  logic               access_sel,
    input  logic [FIELD_W-1:0] file_field,
    input  logic [BANK_W-1:0]  bank_q,
    output logic [ADDR_W-1:0]  addr
);

    logic              upper_half;
    logic [BANK_W-1:0] window_bank;

    always_comb begin
        // Fixed window: the field's top bit selects the first or last bank.
        upper_half  = file_field[FIELD_W-1];
        window_bank = {BANK_W{upper_half}};
        if (access_sel) begin
            addr = {bank_q, file_field};
        end else begin
            addr = {window_bank, file_field};
        end
    end

endmodule

// File: rtl/sfr_detect.sv
module sfr_detect
    import banked_addr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              in_sfr
);

    always_comb begin
        in_sfr = (addr >= SFR_BASE);
    end

endmodule

// File: rtl/banked_addr_gen.sv
module banked_addr_gen
    import banked_addr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [CMD_W-1:0]   instr_word,
    input  logic [FIELD_W-1:0] file_field,
    input  logic               access_sel,
    output logic [BANK_W-1:0]  bank_value,
    output logic [ADDR_W-1:0]  data_addr,
    output logic               sfr_region
);

    logic              load_en;
    logic [BANK_W-1:0] load_lit;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr;

    bank_cmd_decode dec_i (
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .load_en     (load_en),
        .load_lit    (load_lit)
    );

    bank_reg breg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_lit (load_lit),
        .bank_q   (bank_q)
    );

    addr_form form_i (
        .access_sel (access_sel),
        .file_field (file_field),
        .bank_q     (bank_q),
        .addr       (addr)
    );

    sfr_detect sfr_i (
        .addr   (addr),
        .in_sfr (sfr_region)
    );

    assign bank_value = bank_q;
    assign data_addr  = addr;

endmodule

// File: rtl/banked_addr_gen_chk.sv
module banked_addr_gen_chk
    import banked_addr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic [CMD_W-1:0]   instr_word,
    input logic [FIELD_W-1:0] file_field,
    input logic               access_sel,
    input logic [BANK_W-1:0]  bank_value,
    input logic [ADDR_W-1:0]  data_addr,
    input logic               sfr_region
);

    logic is_load;
    assign is_load = instr_valid && (instr_word[CMD_W-1:BANK_W] == LOAD_BANK_OPC);

    // R2: a load-bank command lands on the next edge
    assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> bank_value == $past(instr_word[BANK_W-1:0]));

    // R4: anything else keeps the bank
    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !is_load |=> $stable(bank_value));

    // R5: banked mode prepends the bank register
    assert_banked_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        access_sel |-> (data_addr[ADDR_W-1:FIELD_W] == bank_value
                        && data_addr[FIELD_W-1:0] == file_field));

    // R6: low half of the fixed window is the bottom of memory
    assert_low_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_sel && !file_field[FIELD_W-1]) |->
            data_addr == ADDR_W'(file_field));

    // R7: high half of the fixed window is the top of the last bank
    assert_high_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_sel && file_field[FIELD_W-1]) |->
            (&data_addr[ADDR_W-1:FIELD_W] && data_addr[FIELD_W-1:0] == file_field));

    // R8: region flag follows the mode and field
    assert_sfr_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_sel && file_field[FIELD_W-1]) |-> sfr_region);

    assert_sfr_banked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (access_sel && !(&bank_value)) |-> !sfr_region);

    assert_sfr_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !file_field[FIELD_W-1] |-> !sfr_region);

endmodule

bind banked_addr_gen banked_addr_gen_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .file_field  (file_field),
    .access_sel  (access_sel),
    .bank_value  (bank_value),
    .data_addr   (data_addr),
    .sfr_region  (sfr_region)
);

// File: tb/banked_addr_gen_tb_top.sv
module banked_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic [7:0]  file_field = '0;
    logic        access_sel = 1'b0;
    logic [3:0]  bank_value;
    logic [11:0] data_addr;
    logic        sfr_region;

    int checks = 0;
    int errors = 0;
    logic [3:0] model_bank = 4'h0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    banked_addr_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .file_field  (file_field),
        .access_sel  (access_sel),
        .bank_value  (bank_value),
        .data_addr   (data_addr),
        .sfr_region  (sfr_region)
    );

    function automatic logic [11:0] exp_addr(input logic acc, input logic [7:0] f,
                                             input logic [3:0] b);
        if (acc)          return {b, f};
        else if (!f[7])   return {4'h0, f};
        else              return {4'hF, f};
    endfunction

    function automatic logic exp_sfr(input logic [11:0] a);
        return a >= 12'hF80;
    endfunction

    function automatic string addr_req(input logic acc, input logic [7:0] f);
        if (acc)        return "R5";
        else if (!f[7]) return "R6";
        else            return "R7";
    endfunction

    task automatic check_val(input string req, input string what,
                             input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, update model at posedge.
    task automatic step(input logic v, input logic [15:0] w, input logic acc,
                        input logic [7:0] f, input string bank_req);
        logic [11:0] ea;
        @(negedge clk);
        instr_valid = v;
        instr_word  = w;
        access_sel  = acc;
        file_field  = f;
        #2;
        ea = exp_addr(acc, f, model_bank);
        check_val(bank_req, "bank", int'(bank_value), int'(model_bank));
        check_val(addr_req(acc, f), "addr", int'(data_addr), int'(ea));
        check_val("R8", "sfr", int'(sfr_region), int'(exp_sfr(ea)));
        @(posedge clk);
        if (v && w[15:4] == 12'h010) model_bank = w[3:0];
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check_val("R1", "bank in reset", int'(bank_value), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: bank 0 after reset, banked field 0x70 -> 0x070
        step(1'b0, 16'h0, 1'b1, 8'h70, "R1");
        // R3: load 2 in this cycle, address still uses bank 0
        step(1'b1, 16'h0102, 1'b1, 8'h70, "R3");
        // R2/R5: next cycle bank 2 gives 0x270
        step(1'b0, 16'h0, 1'b1, 8'h70, "R2");
        // R6/R7: access window seam, bank ignored
        step(1'b0, 16'h0, 1'b0, 8'h7F, "R4");
        step(1'b0, 16'h0, 1'b0, 8'h80, "R4");
        step(1'b0, 16'h0, 1'b0, 8'hFF, "R4");
        step(1'b0, 16'h0, 1'b0, 8'h00, "R4");
        // R4: near-miss words and invalid load leave bank at 2
        step(1'b1, 16'h0112, 1'b1, 8'h10, "R4");
        step(1'b1, 16'h0302, 1'b1, 8'h10, "R4");
        step(1'b1, 16'h8105, 1'b1, 8'h10, "R4");
        step(1'b0, 16'h0109, 1'b1, 8'h10, "R4");
        step(1'b0, 16'h0, 1'b1, 8'h10, "R4");
        // R8: bank F in banked mode across 0xF7F / 0xF80
        step(1'b1, 16'h010F, 1'b1, 8'h00, "R2");
        step(1'b0, 16'h0, 1'b1, 8'h7F, "R2");
        step(1'b0, 16'h0, 1'b1, 8'h80, "R8");
        step(1'b0, 16'h0, 1'b0, 8'h7F, "R6");
        // R3: back-to-back loads
        step(1'b1, 16'h0101, 1'b1, 8'h33, "R3");
        step(1'b1, 16'h010E, 1'b1, 8'h33, "R2");
        step(1'b0, 16'h0, 1'b1, 8'h33, "R2");
        // random mix with a fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] w;
            logic v;
            v = ($urandom % 4) != 0;
            if (($urandom % 3) == 0) w = {12'h010, 4'($urandom)};
            else                     w = 16'($urandom);
            step(v, w, 1'($urandom), 8'($urandom), "R4");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule